// File: doc/BRIEF.md
# Memory-Mapped Serial Peripheral Master

This block is a single-lane SPI master driven through a small register bank on a simple 32-bit memory-mapped bus. The bus has a byte address, a write strobe, write data and a read data path that reflects the addressed register in the same cycle. Software first picks a peripheral by writing a select index and an enable bit, then sets the clock polarity, phase, word size and clock divider. Each write to the transmit register launches one full-duplex word of 8 or 16 bits.

When the word finishes, a completion flag rises in the cause register, and the received word can be read back. The completion flag stays set until software writes a value with bit 0 clear to the cause register. Up to eight active-low select lines are decoded from the index. A clock divider, built as its own module, sets the serial clock rate.

The divider setting, the mode and the word size are captured when a word starts. Register writes made while a word is on the wire therefore only affect the next word.

Top module: `spi_master_regs`

## Requirements
- R1: After reset all select lines are high, the serial clock is low, and the control, configuration and cause registers read 0.
- R2: With control bit 0 set, the select line whose number is in control bits 4:2 is driven low and every other line stays high.
- R3: With control bit 0 clear, every select line is high, whatever the index field holds.
- R4: Register offsets are: control 0x00, configuration 0x04, transmit 0x08, receive 0x0C, cause 0x10. Control reads back bits 4:2 and 0. Configuration reads back bit 12 (phase), bit 11 (polarity), bit 5 (16-bit words) and bits 4:0 (divider). All other bits read 0.
- R5: A transmit write while idle starts one word. When the word ends, bit 0 of the cause register reads 1. The receive register then holds the word shifted in: the low 8 bits in 8-bit mode or the low 16 bits in 16-bit mode, with the upper bits 0.
- R6: Data goes out most significant bit first. That is transmit bit 7 in 8-bit mode (configuration bit 5 clear) and bit 15 in 16-bit mode. Incoming bits fill the receive word from its top bit down.
- R7: Idle clock level equals the polarity bit. With phase 0 the master samples input on the leading clock edge and changes output on the trailing edge. With phase 1 it changes output on the leading edge and samples on the trailing edge.
- R8: Each serial clock half period lasts divider+1 system clock cycles. One word produces exactly twice its bit count in clock edges.
- R9: A cause write with bit 0 clear clears the completion flag. A cause write with bit 0 set leaves the flag unchanged.
- R10: A transmit write made while a word is in progress is ignored. The current word goes on unchanged, and no second word follows it.
- R11: Configuration writes during a word do not change that word's rate, mode or length. Once idle, the clock level follows the new polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | N_CS | Active-low select lines |

## Verification
Faults in the bit counter or the shift registers show up within the same word. A word that is too long or too short gives the wrong edge count, and a misordered shift produces wrong data, both in the captured peripheral word and in the receive register. A stale captured mode or divider shows up as uneven half periods, or as wrong data on the very next word. A bad completion flag shows up on the first poll or clear that follows.

// File: rtl/spi_ctl_pkg.sv
// Shared widths, register indices, field positions and the per-word
// transfer settings. Assumes word-aligned 32-bit registers.
package spi_ctl_pkg;
    parameter int WORD_W  = 16;
    parameter int BYTE_W  = 8;
    parameter int PRESC_W = 5;

    localparam int IDX_CTRL  = 0;
    localparam int IDX_CFG   = 1;
    localparam int IDX_TX    = 2;
    localparam int IDX_RX    = 3;
    localparam int IDX_CAUSE = 4;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SEL_LO  = 2;
    localparam int CFG_WIDE_BIT = 5;
    localparam int CFG_CPOL_BIT = 11;
    localparam int CFG_CPHA_BIT = 12;

    typedef struct packed {
        logic               cpha;
        logic               cpol;
        logic               wide;
        logic [PRESC_W-1:0] div;
    } xfer_cfg_t;
endpackage

// File: rtl/spi_clk_div.sv
// Divider tick generator: while enabled, pulses tick once every div+1
// cycles. The count restarts from zero whenever the enable is low.
module spi_clk_div #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == div);

    // count cycles within one half period
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_shift_core.sv
// One-word full-duplex shift engine. Captures the settings at start,
// ignores start while busy, shifts MSB first, and drives a registered
// serial clock that rests at the live polarity while idle.
module spi_shift_core
    import spi_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  xfer_cfg_t         cfg_in,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              busy,
    output logic              finish,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi
);
    localparam int CNT_W = $clog2(2 * WORD_W);
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(2 * WORD_W - 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(2 * BYTE_W - 1);

    xfer_cfg_t         cur_q;
    logic [WORD_W-1:0] sr_tx_q, sr_rx_q;
    logic [CNT_W-1:0]  edge_q;
    logic              busy_q, sclk_q, tick;
    logic              sample_now, shift_now, last_edge;

    spi_clk_div #(.DIV_W(PRESC_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (busy_q),
        .div  (cur_q.div),
        .tick (tick)
    );

    assign last_edge  = edge_q == (cur_q.wide ? LAST_WIDE : LAST_NARROW);
    assign sample_now = tick && (edge_q[0] == cur_q.cpha);
    assign shift_now  = tick && (edge_q[0] != cur_q.cpha) && (edge_q != '0);
    assign finish     = busy_q && tick && last_edge;

    // word sequencing: capture settings, count edges, shift both ways
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cur_q   <= '0;
            sr_tx_q <= '0;
            sr_rx_q <= '0;
            edge_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q  <= 1'b1;
            cur_q   <= cfg_in;
            sr_tx_q <= cfg_in.wide ? tx_word
                       : {tx_word[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
            sr_rx_q <= '0;
            edge_q  <= '0;
        end else if (busy_q && tick) begin
            edge_q <= edge_q + 1'b1;
            if (sample_now) sr_rx_q <= {sr_rx_q[WORD_W-2:0], miso};
            if (shift_now)  sr_tx_q <= {sr_tx_q[WORD_W-2:0], 1'b0};
            if (last_edge)  busy_q  <= 1'b0;
        end
    end

    // serial clock: toggles per tick while busy, tracks polarity while idle
    always_ff @(posedge clk) begin
        if (!rst_n)      sclk_q <= 1'b0;
        else if (busy_q) sclk_q <= tick ? ~sclk_q : sclk_q;
        else             sclk_q <= cfg_in.cpol;
    end

    assign busy    = busy_q;
    assign sclk    = sclk_q;
    assign mosi    = sr_tx_q[WORD_W-1];
    assign rx_word = cur_q.wide ? sr_rx_q
                     : {{(WORD_W-BYTE_W){1'b0}}, sr_rx_q[BYTE_W-1:0]};
endmodule

// File: rtl/spi_master_regs.sv
// Register-mapped SPI master top: bus register bank, completion flag,
// select decode and the shift engine. Reads are combinational on the
// address; writes take effect at the clock edge with bus_we high.
module spi_master_regs
    import spi_ctl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int N_CS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [N_CS-1:0]   spi_cs_n
);
    localparam int SEL_W = $clog2(N_CS);
    localparam int RIDX_W = ADDR_W - 2;

    logic [RIDX_W-1:0] reg_idx;
    logic [SEL_W-1:0]  ctrl_sel_q;
    logic              ctrl_en_q;
    xfer_cfg_t         cfg_q;
    logic              done_q, xfer_busy, xfer_finish;
    logic              wr_ctrl, wr_cfg, wr_tx, cause_clr, xfer_start;
    logic [WORD_W-1:0] rx_word;
    logic              unused_bits;

    assign reg_idx    = bus_addr[ADDR_W-1:2];
    assign wr_ctrl    = bus_we && (reg_idx == RIDX_W'(IDX_CTRL));
    assign wr_cfg     = bus_we && (reg_idx == RIDX_W'(IDX_CFG));
    assign wr_tx      = bus_we && (reg_idx == RIDX_W'(IDX_TX));
    assign cause_clr  = bus_we && (reg_idx == RIDX_W'(IDX_CAUSE)) && !bus_wdata[0];
    assign xfer_start = wr_tx && !xfer_busy;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:WORD_W]};

    // control and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en_q  <= 1'b0;
            ctrl_sel_q <= '0;
            cfg_q      <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_en_q  <= bus_wdata[CTRL_EN_BIT];
                ctrl_sel_q <= bus_wdata[CTRL_SEL_LO +: SEL_W];
            end
            if (wr_cfg) begin
                cfg_q.cpha <= bus_wdata[CFG_CPHA_BIT];
                cfg_q.cpol <= bus_wdata[CFG_CPOL_BIT];
                cfg_q.wide <= bus_wdata[CFG_WIDE_BIT];
                cfg_q.div  <= bus_wdata[PRESC_W-1:0];
            end
        end
    end

    // completion flag: set on word end, cleared by start or a zero write
    always_ff @(posedge clk) begin
        if (!rst_n)           done_q <= 1'b0;
        else if (xfer_finish) done_q <= 1'b1;
        else if (xfer_start)  done_q <= 1'b0;
        else if (cause_clr)   done_q <= 1'b0;
    end

    spi_shift_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (xfer_start),
        .cfg_in (cfg_q),
        .tx_word(bus_wdata[WORD_W-1:0]),
        .miso   (spi_miso),
        .busy   (xfer_busy),
        .finish (xfer_finish),
        .rx_word(rx_word),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi)
    );

    // select decode, one comparator per line
    for (genvar g = 0; g < N_CS; g++) begin : g_cs
        assign spi_cs_n[g] = !(ctrl_en_q && (ctrl_sel_q == SEL_W'(g)));
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (reg_idx)
            RIDX_W'(IDX_CTRL): begin
                bus_rdata[CTRL_EN_BIT]           = ctrl_en_q;
                bus_rdata[CTRL_SEL_LO +: SEL_W]  = ctrl_sel_q;
            end
            RIDX_W'(IDX_CFG): begin
                bus_rdata[CFG_CPHA_BIT]  = cfg_q.cpha;
                bus_rdata[CFG_CPOL_BIT]  = cfg_q.cpol;
                bus_rdata[CFG_WIDE_BIT]  = cfg_q.wide;
                bus_rdata[PRESC_W-1:0]   = cfg_q.div;
            end
            RIDX_W'(IDX_RX):    bus_rdata[WORD_W-1:0] = rx_word;
            RIDX_W'(IDX_CAUSE): bus_rdata[0] = done_q;
            default:            bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_master_chk.sv
// Property checker for spi_master_regs, attached by bind below.
module spi_master_chk #(
    parameter int N_CS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CS-1:0] spi_cs_n,
    input logic            spi_sclk,
    input logic            ctrl_en,
    input logic            busy,
    input logic            done,
    input logic            finish,
    input logic            clr_wr,
    input logic            cfg_cpol
);
    a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~spi_cs_n) <= 1);

    a_r3_select_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> (&spi_cs_n));

    a_r5_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy));

    a_r9_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !finish) |=> !done);

    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> busy);

    a_r11_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> (spi_sclk == $past(cfg_cpol)));
endmodule

bind spi_master_regs spi_master_chk #(.N_CS(N_CS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk),
    .ctrl_en (ctrl_en_q),
    .busy    (xfer_busy),
    .done    (done_q),
    .finish  (xfer_finish),
    .clr_wr  (cause_clr),
    .cfg_cpol(cfg_q.cpol)
);

// File: tb/tb_spi_master_regs.sv
`timescale 1ns/1ps
module tb_spi_master_regs;
    localparam int ADDR_W = 5;
    localparam int N_CS   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              spi_sclk, spi_mosi;
    logic              miso_drv = 1'b0;
    logic [N_CS-1:0]   spi_cs_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // peripheral model state
    bit          armed = 0;
    bit          tb_cpol = 0, tb_cpha = 0;
    logic [15:0] s_pat = '0, cap = '0;
    int          ecount = 0, bad_int = 0;
    longint      t_prev = 0, half_exp = 8;

    always #4 clk = ~clk;

    spi_master_regs #(.ADDR_W(ADDR_W), .N_CS(N_CS)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(miso_drv), .spi_cs_n(spi_cs_n)
    );

    // peripheral: samples and drives on the edges the mode calls for
    always @(spi_sclk) begin
        if (armed) begin
            if (ecount > 0 && ($time - t_prev) != half_exp) bad_int++;
            t_prev = $time;
            ecount++;
            if ((spi_sclk != tb_cpol) ^ tb_cpha) begin
                cap = {cap[14:0], spi_mosi};
            end else if (tb_cpha) begin
                miso_drv = s_pat[15];
                s_pat = {s_pat[14:0], 1'b0};
            end else begin
                s_pat = {s_pat[14:0], 1'b0};
                miso_drv = s_pat[15];
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_addr = ADDR_W'(addr); bus_wdata = data; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_addr = ADDR_W'(addr);
        #1 data = bus_rdata;
    endtask

    task automatic start_word(input bit cpol, input bit cpha, input bit wide,
                              input int div, input logic [15:0] tx, input logic [15:0] pat);
        armed = 0;
        bus_write(32'h04, {19'd0, cpha, cpol, 5'd0, wide, 5'(div)});
        repeat (2) @(negedge clk);
        tb_cpol = cpol; tb_cpha = cpha;
        half_exp = longint'((div + 1) * 8);
        s_pat = wide ? pat : {pat[7:0], 8'h00};
        miso_drv = s_pat[15];
        cap = '0; ecount = 0; bad_int = 0;
        armed = 1;
        bus_write(32'h08, {16'd0, tx});
    endtask

    task automatic finish_word(input bit wide, input logic [15:0] tx, input logic [15:0] pat,
                               input string tag);
        logic [31:0] r;
        logic [15:0] want_cap, want_rx;
        int n;
        r = '0;
        for (int i = 0; i < 3000; i++) begin
            bus_read(32'h10, r);
            if (r[0]) break;
        end
        armed = 0;
        n = wide ? 16 : 8;
        want_cap = wide ? tx : {8'h00, tx[7:0]};
        want_rx  = wide ? pat : {8'h00, pat[7:0]};
        check(r[0] == 1'b1, {tag, " R5 done flag"}, r, 1);
        check((wide ? cap : {8'h00, cap[7:0]}) == want_cap, {tag, " R6 peripheral captured"}, cap, want_cap);
        bus_read(32'h0C, r);
        check(r == {16'd0, want_rx}, {tag, " R5 R7 receive word"}, r, want_rx);
        check(ecount == 2 * n, {tag, " R8 edge count"}, ecount, 2 * n);
        check(bad_int == 0, {tag, " R8 half period"}, bad_int, 0);
        bus_write(32'h10, 32'h0);
    endtask

    initial begin
        logic [31:0] r;
        logic [15:0] tx, pat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(spi_cs_n == '1, "R1 selects high", spi_cs_n, 8'hFF);
        check(spi_sclk == 1'b0, "R1 clock low", spi_sclk, 0);
        bus_read(32'h00, r); check(r == 0, "R1 control", r, 0);
        bus_read(32'h04, r); check(r == 0, "R1 config", r, 0);
        bus_read(32'h10, r); check(r == 0, "R1 cause", r, 0);

        // R4 readback masks
        bus_write(32'h00, 32'hFFFF_FFFF);
        bus_read(32'h00, r); check(r == 32'h1D, "R4 control readback", r, 32'h1D);
        bus_write(32'h04, 32'hFFFF_FFFF);
        bus_read(32'h04, r); check(r == 32'h183F, "R4 config readback", r, 32'h183F);
        bus_write(32'h04, 32'h0);

        // R2 / R3 select decode for every index
        for (int i = 0; i < N_CS; i++) begin
            bus_write(32'h00, 32'(i << 2) | 32'h1);
            @(negedge clk);
            check(spi_cs_n == ~(8'h01 << i), "R2 select decode", spi_cs_n, ~(8'h01 << i));
            bus_write(32'h00, 32'(i << 2));
            @(negedge clk);
            check(spi_cs_n == 8'hFF, "R3 select off", spi_cs_n, 8'hFF);
        end
        bus_write(32'h00, 32'h0D);

        // R5-R8 sweep: modes x widths x dividers x patterns
        for (int m = 0; m < 4; m++)
            for (int w = 0; w < 2; w++)
                for (int d = 0; d < 3; d += 2)
                    for (int p = 0; p < 2; p++) begin
                        tx  = (p == 0) ? 16'hA53C : 16'h0F81 ^ 16'(m * 16'h1111 + d);
                        pat = (p == 0) ? 16'h3CA5 : 16'hE817 ^ 16'(w * 16'h0101 + m);
                        start_word(m[1], m[0], w[0], d, tx, pat);
                        finish_word(w[0], tx, pat, "sweep");
                    end

        // R7 idle level follows polarity
        bus_write(32'h04, 32'h0800);
        repeat (2) @(negedge clk);
        check(spi_sclk == 1'b1, "R7 idle high", spi_sclk, 1);
        bus_write(32'h04, 32'h0);
        repeat (2) @(negedge clk);
        check(spi_sclk == 1'b0, "R7 idle low", spi_sclk, 0);

        // R9 cause write with bit 0 set keeps flag, clear write drops it
        start_word(0, 0, 0, 0, 16'h0055, 16'h00AA);
        for (int i = 0; i < 100; i++) @(negedge clk);
        armed = 0;
        bus_write(32'h10, 32'h1);
        bus_read(32'h10, r); check(r == 1, "R9 keep on write of one", r, 1);
        bus_write(32'h10, 32'h0);
        bus_read(32'h10, r); check(r == 0, "R9 clear on write of zero", r, 0);

        // R10 transmit write while busy is ignored
        start_word(1, 1, 1, 1, 16'hC3A1, 16'h5E27);
        repeat (10) @(negedge clk);
        bus_write(32'h08, 32'h0000_1234);
        finish_word(1, 16'hC3A1, 16'h5E27, "R10 busy");
        armed = 1; ecount = 0;
        repeat (150) @(negedge clk);
        armed = 0;
        check(ecount == 0, "R10 no second word", ecount, 0);

        // R11 config write mid-word does not disturb the word
        start_word(0, 1, 1, 1, 16'h9D42, 16'h71B8);
        repeat (12) @(negedge clk);
        bus_write(32'h04, 32'h0000_0803);
        finish_word(1, 16'h9D42, 16'h71B8, "R11 snapshot");
        repeat (2) @(negedge clk);
        check(spi_sclk == 1'b1, "R11 new idle level", spi_sclk, 1);
        bus_read(32'h04, r); check(r == 32'h0803, "R11 config kept", r, 32'h0803);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule